// File: doc/BRIEF.md
# Three-Level Interrupt Status Tree

This block gathers a wide vector of interrupt sources and presents them to a host through a small byte-wide register window. Sources are grouped eight to a block and blocks eight to a master. A root register summarises the masters, so software walks root, then master, then block to find the sources that fired. Every source has its own trigger setting: rising edge, falling edge, both edges, active-high level or active-low level. Each source can also be fully masked and can have its latched flag cleared.

Per-source state is not addressed directly. Software first writes a block-select register. It then reads that block's latched flags or its live synchronized levels, or it writes one shared configuration byte. That byte names the bit within the selected block and carries a commit flag. The block drives a single summary interrupt line, which is high whenever the root register shows any master.

Top module: `irq_tree_agg`

## Requirements
- R1: The register window starts at BASE_ADDR (default 0x1BB), at these offsets: +0 root, +1 to +4 masters 0 to 3, +5 block select, +6 latched flags of the selected block, +7 configuration (write-only, reads 0), +8 live levels of the selected block. Any address outside the window reads 0. A read strobe loads rd_data at the next clock edge, and rd_data holds its value between reads.
- R2: After reset no flag is latched, every source is fully masked and in edge mode, the block select is 0, and irq_o is low.
- R3: Source n maps to block n/8, bit n%8. Block b maps to master b/8, bit b%8. Master m shows at root bit m+1, and root bit 0 always reads 0.
- R4: A master bit is 1 exactly when its block holds a latched flag whose source is not fully masked.
- R5: A configuration write acts only when data bit 7 is 1. It targets the bit index in data bits 6:4 within the selected block. It stores bit 0 (level mode), bit 1 (falling/low disable) and bit 2 (rising/high disable) for that source only.
- R6: In edge mode, with bit 2 clear a rising edge latches the flag, and with bit 1 clear a falling edge latches it. With both clear, either edge latches it. The flag is set on the third clock edge after the source changes.
- R7: In level mode, bit 2 clear latches the flag while the source is high, and bit 1 clear latches it while the source is low.
- R8: A committed configuration write with data bit 3 set clears the target's latched flag. In that cycle the clear wins over a new latch.
- R9: A source with both bits 1 and 2 set latches nothing new. A flag it had already latched stays visible at +6 but is excluded from the master and root bits.
- R10: Offset +8 returns the selected block's source levels after the two-stage synchronizer, regardless of masking.
- R11: A block select of 32 or above makes +6 and +8 read 0, and configuration writes made while it is selected change nothing.
- R12: irq_o is the OR of root bits 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_IN | Asynchronous interrupt sources |
| addr | input | 16 | Register address |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Registered read data |
| irq_o | output | 1 | Summary interrupt |

## Verification
Some behaviours are checked on every cycle by assertions:
- irq_o agrees with the presence of unmasked latched flags.
- A fully masked source never gains a new flag.
- A committed clear leaves its target's flag at zero.
- Root bit 0 and unmapped or configuration reads always return zero.

Other behaviours only show in the bench's scenarios:
- The trigger modes, as source toggles pass through the synchronizer and the latch.
- The ignored uncommitted and out-of-range writes.
- The level re-latch after a clear.
- The block and master routing of particular sources.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BLK_W = 8;

  localparam logic [15:0] OFS_ROOT = 16'd0;
  localparam logic [15:0] OFS_MST0 = 16'd1;
  localparam logic [15:0] OFS_SEL  = 16'd5;
  localparam logic [15:0] OFS_STAT = 16'd6;
  localparam logic [15:0] OFS_CFG  = 16'd7;
  localparam logic [15:0] OFS_LIVE = 16'd8;
  localparam logic [15:0] OFS_LAST = 16'd8;

  localparam int CB_LVL    = 0;
  localparam int CB_MFE    = 1;
  localparam int CB_MRE    = 2;
  localparam int CB_CLR    = 3;
  localparam int CB_IDX_LO = 4;
  localparam int CB_WE     = 7;

  typedef struct packed {
    logic clr;
    logic mre;
    logic mfe;
    logic lvl;
  } trig_cmd_t;
endpackage

// File: rtl/irqagg_sync2.sv
module irqagg_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irqagg_block.sv
module irqagg_block
  import irqagg_pkg::*;
#(
  parameter int IW = $clog2(BLK_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] lvl_i,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  trig_cmd_t        cmd,
  output logic [BLK_W-1:0] stat_o,
  output logic [BLK_W-1:0] fmask_o,
  output logic             pend_o
);
  for (genvar i = 0; i < BLK_W; i++) begin : g_bit
    logic prev_q, lvl_q, mfe_q, mre_q, st_q;
    logic hit, set, st_d;

    // next state: trigger detect, clear priority
    always_comb begin
      hit = cfg_we && (cfg_idx == IW'(i));
      if (lvl_q) set = (!mre_q && lvl_i[i]) || (!mfe_q && !lvl_i[i]);
      else       set = (!mre_q && lvl_i[i] && !prev_q) ||
                       (!mfe_q && !lvl_i[i] && prev_q);
      st_d = (hit && cmd.clr) ? 1'b0 : (st_q || set);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lvl_q  <= 1'b0;
        mfe_q  <= 1'b1;
        mre_q  <= 1'b1;
        st_q   <= 1'b0;
      end else begin
        prev_q <= lvl_i[i];
        st_q   <= st_d;
        if (hit) begin
          lvl_q <= cmd.lvl;
          mfe_q <= cmd.mfe;
          mre_q <= cmd.mre;
        end
      end
    end

    assign stat_o[i]  = st_q;
    assign fmask_o[i] = mfe_q && mre_q;
  end

  assign pend_o = |(stat_o & ~fmask_o);
endmodule

// File: rtl/irq_tree_agg.sv
module irq_tree_agg
  import irqagg_pkg::*;
#(
  parameter int          NUM_IN    = 256,
  parameter logic [15:0] BASE_ADDR = 16'h01BB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_src,
  input  logic [15:0]       addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq_o
);
  localparam int NBLK = NUM_IN / BLK_W;
  localparam int NMST = (NBLK + BLK_W - 1) / BLK_W;
  localparam int IW   = $clog2(BLK_W);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [NUM_IN-1:0]       src_s, stat_all, fmask_all;
  logic [NMST*BLK_W-1:0]   blk_pend;
  logic [7:0]              sel_q, sel_d, rd_d, root, sel_stat, sel_live;
  logic [15:0]             ofs;
  logic                    in_win, sel_ok, cfg_hit;
  trig_cmd_t               cmd;

  irqagg_sync2 #(.W(NUM_IN)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (irq_src),
    .q_o  (src_s)
  );

  // address decode and config command
  always_comb begin
    ofs     = addr - BASE_ADDR;
    in_win  = (ofs <= OFS_LAST);
    sel_ok  = (int'(sel_q) < NBLK);
    cfg_hit = wr_en && in_win && (ofs == OFS_CFG) && wr_data[CB_WE] && sel_ok;
    cmd     = '{clr: wr_data[CB_CLR], mre: wr_data[CB_MRE],
                mfe: wr_data[CB_MFE], lvl: wr_data[CB_LVL]};
    sel_d   = (wr_en && in_win && (ofs == OFS_SEL)) ? wr_data : sel_q;
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    irqagg_block #(.IW(IW)) u_blk (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .lvl_i  (src_s[b*BLK_W +: BLK_W]),
      .cfg_we (cfg_hit && (sel_q == 8'(b))),
      .cfg_idx(wr_data[CB_IDX_LO +: IW]),
      .cmd    (cmd),
      .stat_o (stat_all[b*BLK_W +: BLK_W]),
      .fmask_o(fmask_all[b*BLK_W +: BLK_W]),
      .pend_o (blk_pend[b])
    );
  end

  if (NMST * BLK_W > NBLK) begin : g_pad
    assign blk_pend[NMST*BLK_W-1:NBLK] = '0;
  end

  // root summary and selected-block views
  always_comb begin
    root = '0;
    for (int m = 0; m < NMST; m++) root[m+1] = |blk_pend[m*BLK_W +: BLK_W];
    sel_stat = '0;
    sel_live = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (sel_q == 8'(b)) begin
        sel_stat = stat_all[b*BLK_W +: BLK_W];
        sel_live = src_s[b*BLK_W +: BLK_W];
      end
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (in_win) begin
      if (ofs == OFS_ROOT)      rd_d = root;
      else if (ofs == OFS_SEL)  rd_d = sel_q;
      else if (ofs == OFS_STAT) rd_d = sel_stat;
      else if (ofs == OFS_LIVE) rd_d = sel_live;
      for (int m = 0; m < NMST; m++)
        if (ofs == OFS_MST0 + 16'(m)) rd_d = blk_pend[m*BLK_W +: BLK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q   <= '0;
      rd_data <= '0;
    end else begin
      sel_q <= sel_d;
      if (rd_en) rd_data <= rd_d;
    end
  end

  assign irq_o = |root;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int          NUM_IN    = 256,
  parameter logic [15:0] BASE_ADDR = 16'h01BB
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              irq_o,
  input logic [NUM_IN-1:0] stat_all,
  input logic [NUM_IN-1:0] fmask_all,
  input logic [7:0]        sel_q
);
  localparam int NBLK = NUM_IN / 8;
  localparam int NIW  = $clog2(NUM_IN);

  logic [15:0]    ofs;
  logic           clr_pend;
  logic [NIW-1:0] clr_idx;

  assign ofs = addr - BASE_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_pend <= 1'b0;
      clr_idx  <= '0;
    end else begin
      clr_pend <= wr_en && (ofs == 16'd7) && wr_data[7] && wr_data[3] &&
                  (int'(sel_q) < NBLK);
      clr_idx  <= NIW'(int'(sel_q) * 8 + int'(wr_data[6:4]));
    end
  end

  // R1: unmapped addresses and the config register read as zero
  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (ofs > 16'd8 || ofs == 16'd7)) |=> (rd_data == 8'h00));

  // R3: root bit 0 never set
  a_r3_root_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == 16'd0) |=> !rd_data[0]);

  // R8: committed clear leaves the target flag low
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |-> !stat_all[clr_idx]);

  // R9: fully masked sources gain no new flag
  a_r9_masked_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & ~$past(stat_all) & $past(fmask_all)) == '0));

  // R12: summary line tracks unmasked latched flags
  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(stat_all & ~fmask_all)));

  a_r12_flag_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_all & ~fmask_all)) |-> irq_o);
endmodule

bind irq_tree_agg irqagg_chk #(.NUM_IN(NUM_IN), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .irq_o    (irq_o),
  .stat_all (stat_all),
  .fmask_all(fmask_all),
  .sel_q    (sel_q)
);

// File: tb/sim_irq_tree_agg.sv
module sim_irq_tree_agg;
  localparam int          N = 256;
  localparam logic [15:0] B = 16'h01BB;
  localparam logic [7:0]  LVL = 8'h01, MFE = 8'h02, MRE = 8'h04, CLR = 8'h08;

  logic         clk, rst_n;
  logic [N-1:0] src;
  logic [15:0]  addr;
  logic         wr_en, rd_en;
  logic [7:0]   wr_data, rd_data;
  logic         irq_o;

  int    vec_cnt, err_cnt;
  string tag;

  // behavioural reference state
  bit         m_d1[N], m_d2[N], m_pv[N], m_lv[N], m_mfe[N], m_mre[N], m_st[N];
  int         m_sel, m_rcnt;
  logic [7:0] m_rd;

  irq_tree_agg #(.NUM_IN(N), .BASE_ADDR(B)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit pend(int n);
    return m_st[n] && !(m_mfe[n] && m_mre[n]);
  endfunction

  function automatic bit blk_any(int b);
    for (int i = 0; i < 8; i++) if (pend(b * 8 + i)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_irq();
    for (int b = 0; b < N / 8; b++) if (blk_any(b)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(int o);
    logic [7:0] v;
    v = 8'h00;
    if (o == 0) begin
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 8; b++) if (blk_any(m * 8 + b)) v[m+1] = 1'b1;
    end else if (o >= 1 && o <= 4) begin
      for (int b = 0; b < 8; b++) v[b] = blk_any((o - 1) * 8 + b);
    end else if (o == 5) begin
      v = 8'(m_sel);
    end else if (o == 6 && m_sel < 32) begin
      for (int i = 0; i < 8; i++) v[i] = m_st[m_sel * 8 + i];
    end else if (o == 8 && m_sel < 32) begin
      for (int i = 0; i < 8; i++) v[i] = m_d2[m_sel * 8 + i];
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int o, tgt;
    bit set;
    if (!rst_n) begin
      for (int n = 0; n < N; n++) begin
        m_d1[n] = 0; m_d2[n] = 0; m_pv[n] = 0; m_lv[n] = 0;
        m_mfe[n] = 1; m_mre[n] = 1; m_st[n] = 0;
      end
      m_sel = 0; m_rd = 8'h00; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      o = int'(addr) - int'(B);
      if (rd_en) m_rd = exp_rd(o);
      tgt = -1;
      if (wr_en && o == 7 && wr_data[7] && m_sel < 32)
        tgt = m_sel * 8 + int'(wr_data[6:4]);
      for (int n = 0; n < N; n++) begin
        if (m_lv[n]) set = (!m_mre[n] && m_d2[n]) || (!m_mfe[n] && !m_d2[n]);
        else set = (!m_mre[n] && m_d2[n] && !m_pv[n]) ||
                   (!m_mfe[n] && !m_d2[n] && m_pv[n]);
        if (n == tgt) begin
          m_st[n] = wr_data[3] ? 1'b0 : (m_st[n] | set);
          m_lv[n] = wr_data[0]; m_mfe[n] = wr_data[1]; m_mre[n] = wr_data[2];
        end else begin
          m_st[n] = m_st[n] | set;
        end
        m_pv[n] = m_d2[n]; m_d2[n] = m_d1[n]; m_d1[n] = src[n];
      end
      if (wr_en && o == 5) m_sel = int'(wr_data);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    bit e;
    e = exp_irq();
    vec_cnt++;
    if (irq_o !== e) begin
      err_cnt++;
      $display("FAIL %s (R12 irq_o) actual %0b expected %0b", tag, irq_o, e);
    end
    vec_cnt++;
    if (rd_data !== m_rd) begin
      err_cnt++;
      $display("FAIL %s (rd_data) actual %02h expected %02h", tag, rd_data, m_rd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 16'h0000;
  endtask

  task automatic rd(logic [15:0] a, string t);
    tag = t;
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; addr = 16'h0000;
    @(negedge clk);
  endtask

  task automatic cfg(int n, logic [7:0] bits);
    wr(B + 16'd5, 8'(n / 8));
    wr(B + 16'd7, 8'h80 | 8'((n % 8) << 4) | bits);
  endtask

  task automatic drive(int n, bit v, int hold);
    @(negedge clk); src[n] = v;
    idle(hold);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    vec_cnt = 0; err_cnt = 0; tag = "R2 reset";
    src = '0; addr = 16'h0000; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R2 reset state, R1 window and unmapped addresses
    rd(B, "R2 root after reset");
    rd(B + 16'd1, "R2 master0 after reset");
    rd(B + 16'd5, "R2 select after reset");
    rd(B + 16'd6, "R2 flags after reset");
    rd(B + 16'd7, "R1 config reads zero");
    rd(B - 16'd1, "R1 below window");
    rd(B + 16'd9, "R1 above window");

    // R6 rising edge on source 5, routing R3 and R4
    cfg(5, MFE | CLR);
    drive(5, 1'b1, 6);
    rd(B + 16'd6, "R6 rising latched");
    rd(B, "R3 root bit1");
    rd(B + 16'd1, "R4 master0 bit0");
    drive(5, 1'b0, 6);
    cfg(5, MFE | CLR);
    rd(B + 16'd6, "R8 clear source 5");

    // R6 falling edge on source 77 (block 9, master 1)
    cfg(77, MRE | CLR);
    drive(77, 1'b1, 6);
    rd(B + 16'd6, "R6 falling ignores rise");
    drive(77, 1'b0, 6);
    rd(B + 16'd6, "R6 falling latched");
    rd(B + 16'd2, "R3 master1 bit1");
    rd(B, "R3 root bit2");

    // R6 both edges on source 200 (block 25, master 3)
    cfg(200, CLR);
    drive(200, 1'b1, 6);
    rd(B + 16'd6, "R6 both rise");
    cfg(200, CLR);
    drive(200, 1'b0, 6);
    rd(B + 16'd6, "R6 both fall");
    rd(B + 16'd4, "R3 master3");

    // R5 uncommitted write ignored
    wr(B + 16'd7, 8'h08 | 8'(0 << 4));
    rd(B + 16'd6, "R5 no commit no clear");

    // R9 mask both edges after latch
    cfg(200, MFE | MRE);
    rd(B + 16'd6, "R9 flag kept");
    rd(B + 16'd4, "R9 master excludes masked");
    cfg(3, MFE | MRE);
    drive(3, 1'b1, 6);
    drive(3, 1'b0, 6);
    rd(B + 16'd6, "R9 masked source no latch");

    // R7 level high on 130, re-latch after clear
    cfg(130, LVL | MFE | CLR);
    drive(130, 1'b1, 6);
    rd(B + 16'd6, "R7 level high latched");
    cfg(130, LVL | MFE | CLR);
    rd(B + 16'd6, "R8 clear then re-latch");
    rd(B + 16'd6, "R7 level re-latched");
    // R7 level low on 255
    cfg(255, LVL | MRE | CLR);
    idle(3);
    rd(B + 16'd6, "R7 level low latched");
    rd(B, "R12 root with several masters");

    // R10 live levels regardless of mask
    wr(B + 16'd5, 8'd0);
    @(negedge clk); src[7:0] = 8'hA5;
    idle(4);
    rd(B + 16'd8, "R10 live block0");
    rd(B + 16'd6, "R10 live leaves flags");

    // R11 out-of-range select
    wr(B + 16'd5, 8'd40);
    rd(B + 16'd6, "R11 flags zero");
    rd(B + 16'd8, "R11 live zero");
    wr(B + 16'd7, 8'h80 | CLR);
    wr(B + 16'd5, 8'd16);
    rd(B + 16'd6, "R11 write ignored");

    // final cleanup, R12 low
    @(negedge clk); src = '0;
    idle(4);
    cfg(130, MFE | MRE | CLR);
    cfg(255, MFE | MRE | CLR);
    cfg(77, MFE | MRE | CLR);
    cfg(200, MFE | MRE | CLR);
    cfg(0, MFE | MRE | CLR);
    cfg(2, MFE | MRE | CLR);
    cfg(5, MFE | MRE | CLR);
    cfg(7, MFE | MRE | CLR);
    idle(4);
    rd(B, "R12 all quiet");
    tag = "R12 end";
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule